// File: doc/BRIEF.md
# Two-Layer Stub Correlation Logic

This block looks for coincidences between two stacked sensor layers. On every bunch crossing it takes two hit vectors, one per layer, each bit standing for a cluster centre at one half-strip position. Every set bit in the lower vector is a seed. For each seed the block searches the upper vector inside an acceptance window. The window is centred on the seed position plus a programmable offset, and its half-width is programmable in half-strips. When the window holds an upper cluster, the seed becomes a stub. A stub is the seed's half-strip address together with a signed bend, which is the distance from the seed to the chosen upper cluster.

Each crossing produces a one-bit trigger flag and up to three stub slots, filled in ascending seed-address order. An overflow flag reports that matched seeds were dropped. Results appear a fixed two clocks after the crossing is presented. A crossing that is not marked valid produces an all-zero result.

Top module: `stub_corr_top`

## Requirements
- R1: A lower hit at position `a` forms a stub when some upper hit at position `a+b` satisfies all three of the following: `|b - offset| <= winHalf`, `|b| <= REACH`, and `a+b` is a real position. No stub is formed if no such upper hit exists.
- R2: The window centre sits at the seed position plus `offset`. `offset` is a signed two's-complement value, so changing it moves the window by that many half-strips.
- R3: When several upper hits qualify, the one with the smallest `|b - offset|` is chosen. If two candidates are equally close, the one with the smaller (more negative) `b` wins.
- R4: The bend field of a stub is `b`, the upper position minus the seed position, written as a BEND_W-bit two's-complement number.
- R5: The address field of a stub is the lower-layer seed position, ADDR_W bits wide (8 bits by default).
- R6: At most MAX_STUBS stubs are reported. Slot 0 holds the lowest matched seed address and later slots hold strictly higher addresses. The stub valid bits are filled from bit 0 upward with no gaps.
- R7: When more seeds match than there are slots, the matches beyond the last slot are dropped and the overflow output is 1. Otherwise overflow is 0.
- R8: trigOut is 1 exactly when at least one stub is reported for the crossing.
- R9: The result for a crossing presented with xingValid high appears two rising edges later, with resultValid high. Back-to-back crossings are accepted. A crossing presented with xingValid low yields resultValid, trigOut, overflow and all stub valid bits at 0.
- R10: While reset is asserted and right after it, every output is 0.
- R11: A candidate position that would lie below position 0 or at or above NUM_HS never matches, even when the window reaches over the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one crossing per cycle |
| rstN | input | 1 | Asynchronous reset, active low |
| xingValid | input | 1 | Marks the current inputs as a crossing to process |
| lowerHits | input | NUM_HS | Cluster-centre flags of the lower (seed) layer, bit i = half-strip i |
| upperHits | input | NUM_HS | Cluster-centre flags of the upper layer, bit i = half-strip i |
| winHalf | input | WIN_W | Window half-width in half-strips |
| offset | input | BEND_W | Signed window-centre correction in half-strips |
| trigOut | output | 1 | At least one stub found in the crossing |
| stubValid | output | MAX_STUBS | Per-slot valid bits, slot 0 at bit 0 |
| stubAddr | output | MAX_STUBS*ADDR_W | Seed address per slot, slot k at bits [k*ADDR_W +: ADDR_W] |
| stubBend | output | MAX_STUBS*BEND_W | Signed bend per slot, slot k at bits [k*BEND_W +: BEND_W] |
| overflow | output | 1 | More matched seeds than slots |
| resultValid | output | 1 | Outputs belong to a valid crossing |

## Verification
The bench builds the block with 16 half-strip positions, a search reach of 3, a 5-bit bend, a 4-bit window and three stub slots. At this size every bend position can be swept exhaustively against every offset from -4 to 4 and every window from 0 to 4. Every pair of competing upper hits can also be swept, which exercises the closest-candidate rule and its tie-break. Edge seeds at positions 0 and 15 are checked with windows that reach over the array boundary. Pseudo-random multi-seed crossings and a fully populated pattern drive slot ordering and overflow, and back-to-back and invalid crossings cover the two-clock pipeline.

// File: rtl/stub_corr_pkg.sv
package stub_corr_pkg;

  // Strobes passed from the control to the datapath
  typedef struct packed {
    logic load1;   // capture per-seed search results
    logic load2;   // capture slot selection
  } corr_ctl_t;

endpackage

// File: rtl/stub_corr_ctrl.sv
module stub_corr_ctrl
  import stub_corr_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      xingValid,
  output corr_ctl_t ctl,
  output logic      resultValid
);

  logic stage1Valid;
  logic stage2Valid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1Valid <= 1'b0;
      stage2Valid <= 1'b0;
    end else begin
      stage1Valid <= xingValid;
      stage2Valid <= stage1Valid;
    end
  end

  assign ctl.load1   = xingValid;
  assign ctl.load2   = stage1Valid;
  assign resultValid = stage2Valid;

endmodule

// File: rtl/stub_corr_dp.sv
module stub_corr_dp
  import stub_corr_pkg::*;
#(
  parameter int NUM_HS    = 254,
  parameter int REACH     = 7,
  parameter int BEND_W    = 5,
  parameter int WIN_W     = 4,
  parameter int MAX_STUBS = 3,
  parameter int ADDR_W    = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  corr_ctl_t                     ctl,
  input  logic [NUM_HS-1:0]             lowerHits,
  input  logic [NUM_HS-1:0]             upperHits,
  input  logic [WIN_W-1:0]              winHalf,
  input  logic signed [BEND_W-1:0]      offset,
  output logic                          trigOut,
  output logic [MAX_STUBS-1:0]          stubValid,
  output logic [MAX_STUBS*ADDR_W-1:0]   stubAddr,
  output logic [MAX_STUBS*BEND_W-1:0]   stubBend,
  output logic                          overflow
);

  localparam int PAD_W = NUM_HS + 2 * REACH;

  // Upper layer padded with empty positions so edge candidates never match
  logic [PAD_W-1:0] upperPad;
  assign upperPad = {{REACH{1'b0}}, upperHits, {REACH{1'b0}}};

  logic [NUM_HS-1:0] matchC;
  logic [BEND_W-1:0] bendC [NUM_HS];

  // Stage 1: per-seed window search, closest to corrected centre wins
  for (genvar s = 0; s < NUM_HS; s++) begin : g_seed
    logic              hitS;
    logic [BEND_W-1:0] bendS;

    always_comb begin : p_search
      int bestD;
      int d;
      hitS  = 1'b0;
      bendS = '0;
      bestD = 1 << 20;
      for (int b = -REACH; b <= REACH; b++) begin
        d = b - int'(offset);
        if (d < 0) d = -d;
        if (lowerHits[s] && upperPad[s + b + REACH] &&
            d <= int'(winHalf) && d < bestD) begin
          hitS  = 1'b1;
          bestD = d;
          bendS = BEND_W'(b);
        end
      end
    end

    assign matchC[s] = hitS;
    assign bendC[s]  = bendS;
  end

  logic [NUM_HS-1:0] hitQ;
  logic [BEND_W-1:0] bendQ [NUM_HS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hitQ <= '0;
      for (int i = 0; i < NUM_HS; i++) bendQ[i] <= '0;
    end else if (ctl.load1) begin
      hitQ <= matchC;
      for (int i = 0; i < NUM_HS; i++) bendQ[i] <= bendC[i];
    end else begin
      hitQ <= '0;
    end
  end

  // Stage 2: pick the lowest matched seeds in ascending order
  logic [MAX_STUBS-1:0] selV;
  logic [ADDR_W-1:0]    selA [MAX_STUBS];
  logic [BEND_W-1:0]    selB [MAX_STUBS];
  logic                 selTrig;
  logic                 selOvf;

  always_comb begin : p_select
    int cnt;
    cnt  = 0;
    selV = '0;
    for (int k = 0; k < MAX_STUBS; k++) begin
      selA[k] = '0;
      selB[k] = '0;
    end
    for (int s = 0; s < NUM_HS; s++) begin
      if (hitQ[s]) begin
        for (int k = 0; k < MAX_STUBS; k++) begin
          if (k == cnt) begin
            selV[k] = 1'b1;
            selA[k] = ADDR_W'(s);
            selB[k] = bendQ[s];
          end
        end
        cnt = cnt + 1;
      end
    end
    selTrig = (cnt != 0);
    selOvf  = (cnt > MAX_STUBS);
  end

  logic [MAX_STUBS-1:0] validQ;
  logic [ADDR_W-1:0]    addrQ [MAX_STUBS];
  logic [BEND_W-1:0]    bendOutQ [MAX_STUBS];
  logic                 trigQ;
  logic                 ovfQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= '0;
      trigQ  <= 1'b0;
      ovfQ   <= 1'b0;
      for (int k = 0; k < MAX_STUBS; k++) begin
        addrQ[k]    <= '0;
        bendOutQ[k] <= '0;
      end
    end else if (ctl.load2) begin
      validQ <= selV;
      trigQ  <= selTrig;
      ovfQ   <= selOvf;
      for (int k = 0; k < MAX_STUBS; k++) begin
        addrQ[k]    <= selA[k];
        bendOutQ[k] <= selB[k];
      end
    end else begin
      validQ <= '0;
      trigQ  <= 1'b0;
      ovfQ   <= 1'b0;
      for (int k = 0; k < MAX_STUBS; k++) begin
        addrQ[k]    <= '0;
        bendOutQ[k] <= '0;
      end
    end
  end

  for (genvar k = 0; k < MAX_STUBS; k++) begin : g_out
    assign stubAddr[k*ADDR_W +: ADDR_W] = addrQ[k];
    assign stubBend[k*BEND_W +: BEND_W] = bendOutQ[k];
  end

  assign stubValid = validQ;
  assign trigOut   = trigQ;
  assign overflow  = ovfQ;

endmodule

// File: rtl/stub_corr_top.sv
module stub_corr_top
  import stub_corr_pkg::*;
#(
  parameter int NUM_HS    = 254,
  parameter int REACH     = 7,
  parameter int BEND_W    = 5,
  parameter int WIN_W     = 4,
  parameter int MAX_STUBS = 3,
  localparam int ADDR_W   = $clog2(NUM_HS)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        xingValid,
  input  logic [NUM_HS-1:0]           lowerHits,
  input  logic [NUM_HS-1:0]           upperHits,
  input  logic [WIN_W-1:0]            winHalf,
  input  logic signed [BEND_W-1:0]    offset,
  output logic                        trigOut,
  output logic [MAX_STUBS-1:0]        stubValid,
  output logic [MAX_STUBS*ADDR_W-1:0] stubAddr,
  output logic [MAX_STUBS*BEND_W-1:0] stubBend,
  output logic                        overflow,
  output logic                        resultValid
);

  corr_ctl_t ctl;

  stub_corr_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .xingValid  (xingValid),
    .ctl        (ctl),
    .resultValid(resultValid)
  );

  stub_corr_dp #(
    .NUM_HS   (NUM_HS),
    .REACH    (REACH),
    .BEND_W   (BEND_W),
    .WIN_W    (WIN_W),
    .MAX_STUBS(MAX_STUBS),
    .ADDR_W   (ADDR_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .lowerHits(lowerHits),
    .upperHits(upperHits),
    .winHalf  (winHalf),
    .offset   (offset),
    .trigOut  (trigOut),
    .stubValid(stubValid),
    .stubAddr (stubAddr),
    .stubBend (stubBend),
    .overflow (overflow)
  );

endmodule

// File: rtl/stub_corr_chk.sv
module stub_corr_chk #(
  parameter int NUM_HS    = 254,
  parameter int BEND_W    = 5,
  parameter int WIN_W     = 4,
  parameter int MAX_STUBS = 3,
  parameter int ADDR_W    = 8
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        xingValid,
  input logic [WIN_W-1:0]            winHalf,
  input logic signed [BEND_W-1:0]    offset,
  input logic                        trigOut,
  input logic [MAX_STUBS-1:0]        stubValid,
  input logic [MAX_STUBS*ADDR_W-1:0] stubAddr,
  input logic [MAX_STUBS*BEND_W-1:0] stubBend,
  input logic                        overflow,
  input logic                        resultValid
);

  // Configuration delayed to line up with the two-clock result
  logic [WIN_W-1:0]  winP1, winP2;
  logic [BEND_W-1:0] offP1, offP2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winP1 <= '0; winP2 <= '0;
      offP1 <= '0; offP2 <= '0;
    end else begin
      winP1 <= winHalf; winP2 <= winP1;
      offP1 <= offset;  offP2 <= offP1;
    end
  end

  int dist0;
  always_comb begin
    dist0 = int'($signed(stubBend[BEND_W-1:0])) - int'($signed(offP2));
    if (dist0 < 0) dist0 = -dist0;
  end

  // R1: a reported stub lies inside the window configured for its crossing
  p_bend_in_window_r1: assert property (@(posedge clk) disable iff (!rstN)
    stubValid[0] |-> (dist0 <= int'(winP2)));

  // R8: trigger set exactly when slot 0 holds a stub
  p_trig_iff_stub_r8: assert property (@(posedge clk) disable iff (!rstN)
    trigOut == stubValid[0]);

  // R7: overflow only when every slot is used
  p_ovf_full_r7: assert property (@(posedge clk) disable iff (!rstN)
    overflow |-> (&stubValid));

  // R9: a result is only presented two clocks after a valid crossing
  p_latency_r9: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> $past(xingValid, 2));

  // R9: no result means nothing reported
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    !resultValid |-> (!trigOut && !overflow && stubValid == '0));

  // R5: reported address is a real position
  p_addr_range_r5: assert property (@(posedge clk) disable iff (!rstN)
    stubValid[0] |-> (int'(stubAddr[ADDR_W-1:0]) < NUM_HS));

  for (genvar k = 1; k < MAX_STUBS; k++) begin : g_slot
    // R6: slots packed from bit 0 upward
    p_slots_packed_r6: assert property (@(posedge clk) disable iff (!rstN)
      stubValid[k] |-> stubValid[k-1]);
    // R6: strictly ascending seed addresses
    p_ascending_r6: assert property (@(posedge clk) disable iff (!rstN)
      stubValid[k] |-> (stubAddr[k*ADDR_W +: ADDR_W] > stubAddr[(k-1)*ADDR_W +: ADDR_W]));
  end

endmodule

bind stub_corr_top stub_corr_chk #(
  .NUM_HS   (NUM_HS),
  .BEND_W   (BEND_W),
  .WIN_W    (WIN_W),
  .MAX_STUBS(MAX_STUBS),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .xingValid  (xingValid),
  .winHalf    (winHalf),
  .offset     (offset),
  .trigOut    (trigOut),
  .stubValid  (stubValid),
  .stubAddr   (stubAddr),
  .stubBend   (stubBend),
  .overflow   (overflow),
  .resultValid(resultValid)
);

// File: tb/stub_corr_top_tb.sv
`timescale 1ns/1ps
module stub_corr_top_tb;

  localparam int N  = 16;
  localparam int RC = 3;
  localparam int BW = 5;
  localparam int WW = 4;
  localparam int MS = 3;
  localparam int AW = 4;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              xingValid = 1'b0;
  logic [N-1:0]      lowerHits = '0;
  logic [N-1:0]      upperHits = '0;
  logic [WW-1:0]     winHalf = '0;
  logic signed [BW-1:0] offset = '0;
  logic              trigOut;
  logic [MS-1:0]     stubValid;
  logic [MS*AW-1:0]  stubAddr;
  logic [MS*BW-1:0]  stubBend;
  logic              overflow;
  logic              resultValid;

  always #2 clk = ~clk;

  stub_corr_top #(.NUM_HS(N), .REACH(RC), .BEND_W(BW), .WIN_W(WW), .MAX_STUBS(MS)) u_dut (
    .clk(clk), .rstN(rstN), .xingValid(xingValid), .lowerHits(lowerHits),
    .upperHits(upperHits), .winHalf(winHalf), .offset(offset), .trigOut(trigOut),
    .stubValid(stubValid), .stubAddr(stubAddr), .stubBend(stubBend),
    .overflow(overflow), .resultValid(resultValid));

  int chkCnt = 0;
  int errCnt = 0;
  bit finished = 0;

  int expTrig, expOvf;
  int expV [MS];
  int expA [MS];
  int expB [MS];
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input string tag, input string field, input int got, input int exp);
    chkCnt++;
    if (got != exp) begin
      errCnt++;
      $display("FAIL %s %s got %0d expected %0d", tag, field, got, exp);
    end
  endtask

  // Reference: search written from the requirements
  task automatic model(input logic [N-1:0] lo, input logic [N-1:0] up, input int win, input int off);
    int cnt;
    cnt = 0;
    for (int k = 0; k < MS; k++) begin expV[k] = 0; expA[k] = 0; expB[k] = 0; end
    for (int s = 0; s < N; s++) begin
      if (lo[s]) begin
        int bestD;
        int bestB;
        bestD = 1000;
        bestB = 0;
        for (int b = -RC; b <= RC; b++) begin
          int p;
          int d;
          p = s + b;
          d = (b - off < 0) ? off - b : b - off;
          if (p >= 0 && p < N && up[p] && d <= win && d < bestD) begin
            bestD = d;
            bestB = b;
          end
        end
        if (bestD != 1000) begin
          if (cnt < MS) begin expV[cnt] = 1; expA[cnt] = s; expB[cnt] = bestB; end
          cnt++;
        end
      end
    end
    expTrig = (cnt > 0) ? 1 : 0;
    expOvf  = (cnt > MS) ? 1 : 0;
  endtask

  task automatic compareOut(input string tag);
    check(tag, "resultValid R9", int'(resultValid), 1);
    check(tag, "trigOut R8", int'(trigOut), expTrig);
    check(tag, "overflow R7", int'(overflow), expOvf);
    for (int k = 0; k < MS; k++) begin
      check(tag, "valid R6", int'(stubValid[k]), expV[k]);
      if (expV[k] != 0) begin
        check(tag, "addr R5", int'(stubAddr[k*AW +: AW]), expA[k]);
        check(tag, "bend R4", int'($signed(stubBend[k*BW +: BW])), expB[k]);
      end
    end
  endtask

  task automatic crossing(input logic [N-1:0] lo, input logic [N-1:0] up,
                          input int win, input int off, input string tag);
    @(negedge clk);
    lowerHits = lo; upperHits = up; winHalf = WW'(win); offset = BW'(off); xingValid = 1'b1;
    @(negedge clk);
    xingValid = 1'b0; lowerHits = '0; upperHits = '0;
    @(negedge clk);
    model(lo, up, win, off);
    compareOut(tag);
  endtask

  function automatic logic [15:0] nextRand(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errCnt++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", chkCnt, errCnt);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: outputs during reset
    check("R10", "trigOut", int'(trigOut), 0);
    check("R10", "valid", int'(stubValid), 0);
    check("R10", "overflow", int'(overflow), 0);
    check("R10", "resultValid", int'(resultValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R10", "trig after release", int'(trigOut), 0);

    // R1 R2 R4: single seed, single upper hit, every bend, offset and window
    for (int b = -RC; b <= RC; b++)
      for (int off = -4; off <= 4; off++)
        for (int win = 0; win <= 4; win++)
          crossing(N'(1) << 8, N'(1) << (8 + b), win, off, "R1_R2");

    // R3: two competing upper hits, closest and tie-break
    for (int b1 = -RC; b1 <= RC; b1++)
      for (int b2 = b1 + 1; b2 <= RC; b2++)
        for (int off = -3; off <= 3; off++)
          for (int win = 1; win <= 4; win += 3)
            crossing(N'(1) << 7, (N'(1) << (7 + b1)) | (N'(1) << (7 + b2)), win, off, "R3");

    // R11: seeds at the edges with the window reaching over the boundary
    for (int off = -4; off <= 4; off++)
      for (int win = 0; win <= 2; win++) begin
        crossing(N'(1), '1, win, off, "R11_low");
        crossing(N'(1) << (N - 1), '1, win, off, "R11_high");
        crossing(N'(1), N'(1) << 2, win, off, "R11_lowsparse");
      end

    // R5 R6 R7 R8: pseudo-random multi-seed crossings
    for (int i = 0; i < 300; i++) begin
      logic [15:0] r1, r2, r3;
      lfsr = nextRand(lfsr); r1 = lfsr;
      lfsr = nextRand(lfsr); r2 = lfsr;
      lfsr = nextRand(lfsr); r3 = lfsr;
      crossing(r1 & r2, r3 & ~r2, int'(r1[1:0]) + 1, int'(r2[2:0]) - 4, "R6_rand");
    end

    // R7: everything populated
    crossing('1, '1, 0, 0, "R7_full");
    // R7: exactly three seeds, no overflow
    crossing(16'h0124, '1, 1, 0, "R7_three");
    // R8: nothing matches
    crossing(16'hFFFF, 16'h0000, 4, 0, "R8_none");

    // R9: crossing presented with xingValid low produces nothing
    @(negedge clk);
    lowerHits = '1; upperHits = '1; winHalf = 4'd3; offset = '0; xingValid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R9", "invalid trig", int'(trigOut), 0);
    check("R9", "invalid valid", int'(stubValid), 0);
    check("R9", "invalid resultValid", int'(resultValid), 0);

    // R9: back-to-back crossings keep a two-clock latency
    @(negedge clk);
    lowerHits = 16'h0010; upperHits = 16'h0020; winHalf = 4'd2; offset = '0; xingValid = 1'b1;
    @(negedge clk);
    lowerHits = 16'h0300; upperHits = 16'h0100; winHalf = 4'd1; offset = 5'sd0; xingValid = 1'b1;
    @(negedge clk);
    xingValid = 1'b0; lowerHits = '0; upperHits = '0;
    model(16'h0010, 16'h0020, 2, 0);
    compareOut("R9_stream_a");
    @(negedge clk);
    model(16'h0300, 16'h0100, 1, 0);
    compareOut("R9_stream_b");
    @(negedge clk);
    check("R9", "stream drained", int'(resultValid), 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", chkCnt, errCnt);
    $finish;
  end

endmodule